// File: doc/BRIEF.md
# Supply Supervisor Reset Sequencer

This block is the digital half of a supply supervisor. An external comparator reports, already synchronized to the block clock, whether the supply sits below its trip level. While it does, the block holds a chip reset. Once the supply is good again, the reset stays on for a long, fixed number of clock cycles before it lets go. Any dip during that wait starts the wait over. A separate write-inhibit flag tells a neighbouring memory block when stores must be refused. That flag follows the supply only, from power-up until the first good level.

The reset leaves the chip through an open-drain pad. The block can only pull the pin toward its active level, or release it. One build parameter sets the active level: low in one build, high in the other. In the active-low build the same pin also works as a push-button input. If another device holds the pin at its active level for several synchronized samples while the block is not driving it, that counts as a manual reset. The block then leaves the pin to that device, keeps its own reset on, and runs the full release wait after the pin is let go. The block's own asynchronous power-on reset forces every output to its safe state before any clocked state is valid.

Top module: `rst_supervisor`

## Requirements
- R1: When `supply_low_i` is 1 at a rising edge, `rst_asserted_o` is 1 after that edge and stays 1 while the flag stays 1.
- R2: After the supply recovers, `rst_asserted_o` falls at the DELAY_CYCLES-th consecutive rising edge that samples `supply_low_i` at 0. The first such edge counts as 1.
- R3: A supply dip of one or more cycles during the release wait restarts it. The fall then comes DELAY_CYCLES edges after the last edge that sampled the dip.
- R4: The pad is open-drain. `pad_do_o` is the active level: 0 when ACTIVE_LOW is 1, and 1 when it is 0. `pad_oe_o` is 1 only while `rst_asserted_o` is 1, and it is 1 whenever the reset comes from the supply.
- R5: While `rst_n` is 0, `rst_asserted_o`, `pad_oe_o` and `wr_inhibit_o` are all 1, even before the first clock edge.
- R6: `wr_inhibit_o` is 1 in the same cycle that `supply_low_i` is 1. It returns to 0 at the first rising edge that samples the supply good. A manual reset does not raise it.
- R7: In the active-low build, suppose `pad_i` reads 0 for DEBOUNCE consecutive synchronized samples while the block is not driving the pad. Then `rst_asserted_o` rises, and `pad_oe_o` stays 0 for as long as the pin is held.
- R8: After a manual reset, `rst_asserted_o` falls on the (DELAY_CYCLES+3)-th rising edge, counting the first edge that samples the pin released. If the supply is low or recovers later, the later of the two waits sets the fall.
- R9: A pull on the pin that lasts fewer than DEBOUNCE clock cycles never raises the reset. The block's own release of the pin never retriggers it.
- R10: In the active-high build, an external pull of the pin has no effect on `rst_asserted_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Power-on reset, active low |
| supply_low_i | input | 1 | Synchronized comparator flag, 1 = supply under trip level |
| pad_i | input | 1 | Sensed level of the reset pin |
| pad_oe_o | output | 1 | Open-drain enable, 1 = pull the pin to the active level |
| pad_do_o | output | 1 | Level driven when enabled (the active level) |
| rst_asserted_o | output | 1 | Internal reset request, 1 = reset, independent of polarity |
| wr_inhibit_o | output | 1 | 1 = memory writes must be refused |

## Verification
The supply-driven release wait and the manual-reset release wait can end in the same cycle. Each can also outlast the other. The bench holds a manual reset, drops the supply underneath it, and then releases the pin and restores the supply with offsets from three cycles apart up to the same edge. Each run is judged by one fall edge, computed as the later of the supply wait and the pin-release wait. A sweep of pulse widths around the debounce length and a sweep of dip positions across the whole release window cover the edges of each function on its own.

// File: rtl/rs_pkg.sv
// Shared constants and helpers for the reset supervisor.
// Assumes: nothing beyond IEEE 1800-2017.
package rs_pkg;

    // Depth of the pad synchronizer; the debounce length must exceed it.
    localparam int unsigned SYNC_STAGES = 2;

    // Pin level that means "reset" for the chosen polarity.
    function automatic logic drive_level(input bit active_low);
        return active_low ? 1'b0 : 1'b1;
    endfunction

endpackage

// File: rtl/rs_pin_sense.sv
// Senses an external pull on the open-drain reset pin.
// Synchronizes the pin and counts consecutive active samples taken while the
// block itself is not driving. It then latches a manual-hold flag, which
// clears at the first synchronized inactive sample.
// Assumes: DEBOUNCE > SYNC_STAGES, so stale samples left over from the
// block's own drive cannot complete a count.
module rs_pin_sense #(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned DEBOUNCE    = 4,
    parameter bit          SENSE_EN    = 1'b1,
    parameter logic        ACT_LVL     = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    input  logic driving_i,
    output logic hold_o
);
    localparam int unsigned DCW = (DEBOUNCE > 1) ? $clog2(DEBOUNCE) : 1;
    localparam logic [DCW-1:0] D_LAST = DCW'(DEBOUNCE - 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [DCW-1:0]         dcnt_q;
    logic                   hold_q;
    logic                   act;

    // Bring the asynchronous pin level into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= {SYNC_STAGES{~ACT_LVL}};
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
    end

    assign act = (sync_q[SYNC_STAGES-1] == ACT_LVL);

    // Count consecutive active samples seen while the pad is undriven.
    always_ff @(posedge clk) begin
        if (!rst_n || !act || driving_i || hold_q) dcnt_q <= '0;
        else if (dcnt_q != D_LAST)                 dcnt_q <= dcnt_q + 1'b1;
    end

    // Latch a manual request on the final sample; drop it when the pin lets go.
    always_ff @(posedge clk) begin
        if (!rst_n)      hold_q <= 1'b0;
        else if (hold_q) hold_q <= act;
        else             hold_q <= SENSE_EN && act && !driving_i && (dcnt_q == D_LAST);
    end

    assign hold_o = hold_q;
endmodule

// File: rtl/rs_release_timer.sv
// Holds reset while its hold input is set. After the input clears, it keeps
// reset on for DELAY_CYCLES edges. Any new hold clears the count.
// Assumes: DELAY_CYCLES >= 2; hold_i is synchronous to clk.
module rs_release_timer #(
    parameter int unsigned DELAY_CYCLES = 10_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold_i,
    output logic asserted_o
);
    localparam int unsigned CW = $clog2(DELAY_CYCLES + 1);
    localparam logic [CW-1:0] C_LAST = CW'(DELAY_CYCLES - 1);

    logic [CW-1:0] cnt_q;
    logic          asserted_q;

    // Restart on hold, otherwise count down the release wait once.
    always_ff @(posedge clk) begin
        if (!rst_n || hold_i) begin
            asserted_q <= 1'b1;
            cnt_q      <= '0;
        end else if (asserted_q) begin
            if (cnt_q == C_LAST) begin
                asserted_q <= 1'b0;
                cnt_q      <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign asserted_o = asserted_q;
endmodule

// File: rtl/rs_wr_guard.sv
// Write-inhibit flag for the memory neighbour. It rises at once with a low
// supply and falls one edge after the supply is sampled good.
// Assumes: supply_low_i is synchronous to clk.
module rs_wr_guard (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_low_i,
    output logic inhibit_o
);
    logic low_q;

    // Remember the last sampled supply state; power-up counts as low.
    always_ff @(posedge clk) begin
        if (!rst_n) low_q <= 1'b1;
        else        low_q <= supply_low_i;
    end

    assign inhibit_o = ~rst_n | low_q | supply_low_i;
endmodule

// File: rtl/rst_supervisor.sv
// Top of the reset supervisor. It merges the supply flag and the manual
// request into one hold, times the release, and drives the open-drain pad.
// While a manual hold is active the pad is left to the external device.
// Assumes: supply_low_i is already synchronized.
module rst_supervisor #(
    parameter bit          ACTIVE_LOW   = 1'b1,
    parameter int unsigned DELAY_CYCLES = 10_000_000,
    parameter int unsigned DEBOUNCE     = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_low_i,
    input  logic pad_i,
    output logic pad_oe_o,
    output logic pad_do_o,
    output logic rst_asserted_o,
    output logic wr_inhibit_o
);
    localparam logic ACT_LVL = rs_pkg::drive_level(ACTIVE_LOW);

    logic man_hold;
    logic timed_rst;
    logic hold;

    rs_pin_sense #(
        .SYNC_STAGES (rs_pkg::SYNC_STAGES),
        .DEBOUNCE    (DEBOUNCE),
        .SENSE_EN    (ACTIVE_LOW),
        .ACT_LVL     (ACT_LVL)
    ) u_sense (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_i     (pad_i),
        .driving_i (pad_oe_o),
        .hold_o    (man_hold)
    );

    assign hold = supply_low_i | man_hold;

    rs_release_timer #(
        .DELAY_CYCLES (DELAY_CYCLES)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .hold_i     (hold),
        .asserted_o (timed_rst)
    );

    rs_wr_guard u_guard (
        .clk          (clk),
        .rst_n        (rst_n),
        .supply_low_i (supply_low_i),
        .inhibit_o    (wr_inhibit_o)
    );

    assign rst_asserted_o = ~rst_n | timed_rst;
    assign pad_oe_o       = ~rst_n | (timed_rst & ~man_hold);
    assign pad_do_o       = ACT_LVL;
endmodule

// File: rtl/rs_checker.sv
// Port-level properties of the reset supervisor, bound into every instance.
// Assumes: synchronous active-low rst_n.
module rs_checker #(
    parameter int unsigned DELAY_CYCLES = 10_000_000
) (
    input logic clk,
    input logic rst_n,
    input logic supply_low_i,
    input logic pad_oe_o,
    input logic rst_asserted_o,
    input logic wr_inhibit_o
);
    logic [31:0] quiet_q;

    // Count edges since the supply was last sampled low.
    always_ff @(posedge clk) begin
        if (!rst_n || supply_low_i) quiet_q <= '0;
        else if (quiet_q != '1)     quiet_q <= quiet_q + 1'b1;
    end

    AST_SUPPLY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        supply_low_i |=> rst_asserted_o); // R1

    AST_FULL_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_asserted_o) |-> (quiet_q >= 32'(DELAY_CYCLES))); // R2

    AST_DRIVE_ONLY_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        pad_oe_o |-> rst_asserted_o); // R4

    AST_INHIBIT_ON_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        supply_low_i |-> wr_inhibit_o); // R6

    AST_INHIBIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(!supply_low_i) && !supply_low_i) |-> !wr_inhibit_o); // R6

    // Power-on state is forced before any clocked state exists.
    always_comb begin
        if (rst_n == 1'b0) begin
            AST_POR_STATE: assert (rst_asserted_o && pad_oe_o && wr_inhibit_o); // R5
        end
    end
endmodule

bind rst_supervisor rs_checker #(.DELAY_CYCLES(DELAY_CYCLES)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .supply_low_i   (supply_low_i),
    .pad_oe_o       (pad_oe_o),
    .rst_asserted_o (rst_asserted_o),
    .wr_inhibit_o   (wr_inhibit_o)
);

// File: tb/rst_supervisor_tb.sv
module rst_supervisor_tb;
    localparam int DLY = 20;
    localparam int DEB = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic supply_low = 1'b1;
    logic ext_lo = 1'b0;
    logic ext_hi = 1'b0;
    int   cyc = 0;
    int   nchk = 0;
    int   nerr = 0;

    logic oe_lo, do_lo, rst_lo, wi_lo, pad_lo;
    logic oe_hi, do_hi, rst_hi, wi_hi, pad_hi;

    // Open-drain pins: driven or externally pulled to the active level.
    assign pad_lo = ~(oe_lo | ext_lo);
    assign pad_hi = oe_hi | ext_hi;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    rst_supervisor #(.ACTIVE_LOW(1'b1), .DELAY_CYCLES(DLY), .DEBOUNCE(DEB)) u_dut (
        .clk(clk), .rst_n(rst_n), .supply_low_i(supply_low), .pad_i(pad_lo),
        .pad_oe_o(oe_lo), .pad_do_o(do_lo), .rst_asserted_o(rst_lo), .wr_inhibit_o(wi_lo));

    rst_supervisor #(.ACTIVE_LOW(1'b0), .DELAY_CYCLES(DLY), .DEBOUNCE(DEB)) u_dut_hi (
        .clk(clk), .rst_n(rst_n), .supply_low_i(supply_low), .pad_i(pad_hi),
        .pad_oe_o(oe_hi), .pad_do_o(do_hi), .rst_asserted_o(rst_hi), .wr_inhibit_o(wi_hi));

    task automatic check_eq(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Wait at negedges until the active-low build releases; return the edge index.
    task automatic wait_fall(output int c);
        int n = 0;
        while (rst_lo == 1'b1 && n < 500) begin
            @(negedge clk);
            n++;
        end
        c = cyc;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nchk++;
        nerr++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        int c0, c1, fc, exp_fall;
        bit seen;
        #5;
        check_eq("R5 rst during por", int'(rst_lo), 1);
        check_eq("R5 oe during por", int'(oe_lo), 1);
        check_eq("R5 wi during por", int'(wi_lo), 1);
        check_eq("R4 active-low drive level", int'(do_lo), 0);
        check_eq("R4 active-high drive level", int'(do_hi), 1);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check_eq("R1 held while supply low", int'(rst_lo), 1);
        check_eq("R4 pad driven while supply low", int'(oe_lo), 1);
        check_eq("R4 hi pad driven while supply low", int'(oe_hi), 1);

        // R2 and R6: first recovery
        supply_low = 1'b0;
        c0 = cyc;
        #1 check_eq("R6 inhibit before sampling", int'(wi_lo), 1);
        @(negedge clk);
        check_eq("R6 inhibit clears one edge later", int'(wi_lo), 0);
        wait_fall(fc);
        check_eq("R2 release edge", fc, c0 + DLY);
        check_eq("R2 hi build releases same edge", int'(rst_hi), 0);
        check_eq("R4 pad released", int'(oe_lo), 0);

        // R1 and R6: dip
        @(negedge clk);
        supply_low = 1'b1;
        #1 check_eq("R6 inhibit same cycle", int'(wi_lo), 1);
        check_eq("R1 not yet sampled", int'(rst_lo), 0);
        @(negedge clk);
        check_eq("R1 asserted after edge", int'(rst_lo), 1);
        check_eq("R4 pad driven on dip", int'(oe_lo), 1);
        repeat (2) @(negedge clk);
        supply_low = 1'b0;
        c0 = cyc;
        wait_fall(fc);
        check_eq("R2 release after dip", fc, c0 + DLY);

        // R3: dip at every position of the release window
        for (int j = 1; j < DLY; j++) begin
            @(negedge clk);
            supply_low = 1'b1;
            @(negedge clk);
            supply_low = 1'b0;
            repeat (j) @(negedge clk);
            supply_low = 1'b1;
            check_eq("R3 still held at dip", int'(rst_lo), 1);
            @(negedge clk);
            supply_low = 1'b0;
            c1 = cyc;
            wait_fall(fc);
            check_eq("R3 restart after dip", fc, c1 + DLY);
        end

        // R7, R8, R9: pull widths around the debounce length
        for (int p = 1; p <= DEB + 3; p++) begin
            repeat (3) @(negedge clk);
            ext_lo = 1'b1;
            repeat (p) @(negedge clk);
            ext_lo = 1'b0;
            c1 = cyc;
            seen = 1'b0;
            fc = 0;
            for (int k = 0; k < DLY + 12; k++) begin
                @(negedge clk);
                if (rst_lo) seen = 1'b1;
                else if (seen && fc == 0) fc = cyc;
            end
            if (p < DEB) begin
                check_eq("R9 short pull ignored", int'(seen), 0);
            end else begin
                check_eq("R7 pull recognised", int'(seen), 1);
                check_eq("R8 manual release edge", fc, c1 + DLY + 3);
                check_eq("R9 no self retrigger", int'(rst_lo), 0);
            end
        end

        // R7 and R6: long hold leaves the pad to the external device
        ext_lo = 1'b1;
        repeat (12) @(negedge clk);
        check_eq("R7 reset during hold", int'(rst_lo), 1);
        check_eq("R7 pad not driven during hold", int'(oe_lo), 0);
        check_eq("R6 manual does not inhibit", int'(wi_lo), 0);
        ext_lo = 1'b0;
        c1 = cyc;
        wait_fall(fc);
        check_eq("R8 long hold release", fc, c1 + DLY + 3);

        // R8 collision: pin release and supply recovery at offsets
        for (int k = -3; k <= 3; k++) begin
            int cr, cs;
            repeat (3) @(negedge clk);
            ext_lo = 1'b1;
            repeat (10) @(negedge clk);
            supply_low = 1'b1;
            repeat (3) @(negedge clk);
            if (k >= 0) begin
                ext_lo = 1'b0;
                cr = cyc;
                repeat (k) @(negedge clk);
                supply_low = 1'b0;
                cs = cyc;
            end else begin
                supply_low = 1'b0;
                cs = cyc;
                repeat (-k) @(negedge clk);
                ext_lo = 1'b0;
                cr = cyc;
            end
            exp_fall = (cs + DLY > cr + DLY + 3) ? cs + DLY : cr + DLY + 3;
            wait_fall(fc);
            check_eq("R8 with supply overlap", fc, exp_fall);
        end

        // R10: active-high build ignores pulls
        @(negedge clk);
        ext_hi = 1'b1;
        seen = 1'b0;
        repeat (DEB + 10) begin
            @(negedge clk);
            if (rst_hi) seen = 1'b1;
        end
        ext_hi = 1'b0;
        check_eq("R10 hi build ignores pull", int'(seen), 0);
        check_eq("R10 hi pad not driven", int'(oe_hi), 0);

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule